// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves bytes over a two-wire synchronous link in half duplex. One pin carries a shift clock that the block always drives. The other pin carries data in either direction. The block sends data with its output enable asserted and samples the pin when it receives. All timing follows an oscillator clock plus an enable that pulses once per machine cycle, and one bit period equals one machine cycle.

The host sees a small register-style port. Writing the buffer while the port is idle starts a transmit. Pulsing the receive-flag clear while receive is enabled starts a receive. Each transfer carries eight bits, least significant first, and ends by setting the transmit-done or receive-done flag. That flag stays set until the host clears it. A received byte is read from `rd_data`.

Top module: `sync_shift_port`

## Requirements
- R1: After reset `sclk_o` is 1, `sdata_oe` is 0, `ti` and `ri` are 0 and `rd_data` is 0.
- R2: When idle, a `wr_en` pulse starts a transmit of `wr_data`. Its eight bits appear on `sdata_o` least significant first, with bit k held for the whole of the k-th bit period.
- R3: Within a transfer, `sclk_o` goes low at the start of each bit period, stays low for OSC_PER_CYC/2 oscillator cycles and then returns high. There are exactly eight such low pulses per transfer, and `sclk_o` is 1 whenever no bit is being shifted.
- R4: While transmitting, `sdata_o` changes only at a bit-period start, so it is stable across each rising edge of `sclk_o`.
- R5: `ti` (after a transmit) or `ri` (after a receive) becomes 1 at the end of the eighth bit period. It stays 1 until a `ti_clr` or `ri_clr` pulse clears it.
- R6: When idle with `rx_en`=1, an `ri_clr` pulse starts a receive. `sdata_i` is sampled at each rising edge of `sclk_o`, least significant bit first, and the assembled byte is on `rd_data` when `ri` becomes 1.
- R7: An `ri_clr` pulse with `rx_en`=0 starts no transfer: `sclk_o` stays 1 and `ri` stays 0.
- R8: A `wr_en` or `ri_clr` pulse while a transfer is pending or running is ignored. The byte in flight is unchanged and no second transfer follows.
- R9: `sdata_oe` is 1 only during the bit periods of a transmit, never during a receive.
- R10: A triggered transfer waits for the next `cyc_en` pulse, so each bit period starts on a machine-cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One-cycle pulse at each machine-cycle start, every OSC_PER_CYC clocks |
| wr_en | input | 1 | Buffer write strobe (starts a transmit) |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| rx_en | input | 1 | Receive enable |
| ti_clr | input | 1 | Clears the transmit-done flag |
| ri_clr | input | 1 | Clears the receive-done flag (starts a receive when enabled) |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| sclk_o | output | 1 | Shift clock pin |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with DATA_W=8 and OSC_PER_CYC=6, so a whole byte takes 48 clocks. This lets many transfers, including all-zero, all-one and single-bit patterns, fit in a short run. The three-clock low half still leaves the data a clear setup window before each rising edge and the sampling point a clear margin after it. The ignore cases are observed through the pins: the count of clock pulses and the byte that arrives show whether a stray write or clear took effect.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2
  } ssp_state_e;

  // clock cycle (counted from the period start) whose edge raises the shift clock
  function automatic int unsigned rise_index(input int unsigned per);
    return per / 2 - 1;
  endfunction
endpackage

// File: rtl/ssp_phase.sv
module ssp_phase #(
  parameter int unsigned OSC_PER_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  output logic at_mid
);
  localparam int unsigned PW = $clog2(OSC_PER_CYC);
  localparam logic [PW-1:0] MID  = PW'(ssp_pkg::rise_index(OSC_PER_CYC));
  localparam logic [PW-1:0] LAST = PW'(OSC_PER_CYC - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n)          ph <= LAST;
    else if (cyc_en)     ph <= '0;
    else if (ph != LAST) ph <= ph + 1'b1;
  end

  assign at_mid = (ph == MID) && !cyc_en;
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq #(
  parameter int unsigned BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic at_mid,
  input  logic start_tx,
  input  logic start_rx,
  output logic busy,
  output logic shifting,
  output logic dir_tx,
  output logic sclk,
  output logic step_tx,
  output logic sample_rx,
  output logic done
);
  import ssp_pkg::*;
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  ssp_state_e state;
  logic [CW-1:0] cnt;
  logic last_bit;

  assign busy      = (state != ST_IDLE);
  assign shifting  = (state == ST_SHIFT);
  assign last_bit  = (cnt == LAST_BIT);
  assign done      = shifting && cyc_en && last_bit;
  assign step_tx   = shifting && cyc_en && !last_bit && dir_tx;
  assign sample_rx = shifting && at_mid && !dir_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      dir_tx <= 1'b0;
      sclk   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_tx || start_rx) begin
            state  <= ST_ARMED;
            dir_tx <= start_tx;
          end
        end
        ST_ARMED: begin
          if (cyc_en) begin
            state <= ST_SHIFT;
            cnt   <= '0;
            sclk  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (cyc_en) begin
            if (last_bit) begin
              state <= ST_IDLE;
              sclk  <= 1'b1;
            end else begin
              cnt  <= cnt + 1'b1;
              sclk <= 1'b0;
            end
          end else if (at_mid) begin
            sclk <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> sclk);
  assert_start_on_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shifting) |-> $past(cyc_en));
endmodule

// File: rtl/ssp_shreg.sv
module ssp_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_tx,
  input  logic         sample_rx,
  input  logic         din,
  input  logic         done_rx,
  output logic         bit_out,
  output logic [W-1:0] rx_buf
);
  logic [W-1:0] sr;

  function automatic logic [W-1:0] shr_in(input logic [W-1:0] v, input logic b);
    return {b, v[W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         sr <= '0;
    else if (load)      sr <= load_val;
    else if (step_tx)   sr <= shr_in(sr, 1'b0);
    else if (sample_rx) sr <= shr_in(sr, din);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_buf <= '0;
    else if (done_rx) rx_buf <= sr;
  end

  assign bit_out = sr[0];
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSC_PER_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_en,
  input  logic              ti_clr,
  input  logic              ri_clr,
  output logic              ti,
  output logic              ri,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i
);
  logic at_mid, busy, shifting, dir_tx, step_tx, sample_rx, done;
  logic start_tx, start_rx, done_tx, done_rx;

  assign start_tx = wr_en && !busy;
  assign start_rx = ri_clr && rx_en && !busy && !wr_en;
  assign done_tx  = done && dir_tx;
  assign done_rx  = done && !dir_tx;

  ssp_phase #(.OSC_PER_CYC(OSC_PER_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .at_mid(at_mid)
  );

  ssp_seq #(.BITS(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .at_mid(at_mid),
    .start_tx(start_tx), .start_rx(start_rx), .busy(busy),
    .shifting(shifting), .dir_tx(dir_tx), .sclk(sclk_o),
    .step_tx(step_tx), .sample_rx(sample_rx), .done(done)
  );

  ssp_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(start_tx), .load_val(wr_data),
    .step_tx(step_tx), .sample_rx(sample_rx), .din(sdata_i),
    .done_rx(done_rx), .bit_out(sdata_o), .rx_buf(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ti <= 1'b0;
    else if (done_tx) ti <= 1'b1;
    else if (ti_clr)  ti <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ri <= 1'b0;
    else if (done_rx) ri <= 1'b1;
    else if (ri_clr)  ri <= 1'b0;
  end

  assign sdata_oe = shifting && dir_tx;

  assert_dout_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $rose(sclk_o)) |-> $stable(sdata_o));
  assert_ti_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> $past(done_tx));
  assert_ti_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);
  assert_no_rx_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_clr && !rx_en && !wr_en && !busy) |=> !busy);
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && shifting) |=> shifting);
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  localparam int unsigned DW  = 8;
  localparam int unsigned CYC = 6;
  localparam int unsigned HALF = CYC / 2;

  logic clk = 1'b0, rst_n = 1'b0, cyc_en = 1'b0;
  logic wr_en = 1'b0, rx_en = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0, sdata_i = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ti, ri, sclk_o, sdata_o, sdata_oe;

  always #10 clk = ~clk;

  sync_shift_port #(.DATA_W(DW), .OSC_PER_CYC(CYC)) i_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr),
    .ti(ti), .ri(ri), .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .sdata_i(sdata_i)
  );

  int checks = 0, errors = 0;
  int unsigned ccnt = 0, cycles = 0, falls = 0, low_len = 0;
  logic [DW-1:0] exp_tx[$], exp_rx[$];
  logic [DW-1:0] tx_got = '0, rx_pat = '0;
  int unsigned tx_n = 0, rx_idx = 0, oe_in_rx = 0;
  logic rx_mode = 1'b0;
  logic p_sclk = 1'b1, p_ti = 1'b0, p_ri = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // machine-cycle enable, monitor and scoreboard in one negedge process
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
    if (rst_n) begin
      if (p_sclk && !sclk_o) begin
        falls++;
        chk(cyc_en == 1'b1, "R10 fall on cycle boundary", cyc_en, 1);
        if (rx_mode) begin
          sdata_i = rx_pat[rx_idx];
          rx_idx++;
        end
        low_len = 0;
      end
      if (!sclk_o) low_len++;
      if (!p_sclk && sclk_o && (sdata_oe || rx_mode)) begin
        chk(low_len == HALF, "R3 low half length", low_len, HALF);
        if (sdata_oe && tx_n < DW) begin
          tx_got[tx_n] = sdata_o;
          tx_n++;
        end
      end
      if (rx_mode && sdata_oe) oe_in_rx++;
      if (ti && !p_ti) begin
        if (exp_tx.size() == 0) chk(1'b0, "R8 unexpected transmit", tx_got, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_tx.pop_front();
          chk(tx_got == e, "R2 transmitted byte", tx_got, e);
          chk(tx_n == DW, "R3 eight clock pulses", tx_n, DW);
        end
      end
      if (ri && !p_ri) begin
        rx_mode = 1'b0;
        if (exp_rx.size() == 0) chk(1'b0, "R8 unexpected receive", rd_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rx.pop_front();
          chk(rd_data == e, "R6 received byte", rd_data, e);
          chk(oe_in_rx == 0, "R9 no drive during receive", oe_in_rx, 0);
        end
      end
    end
    p_sclk = sclk_o; p_ti = ti; p_ri = ri;
    ccnt = (ccnt == CYC - 1) ? 0 : ccnt + 1;
    cyc_en = (ccnt == 0);
  end

  task automatic send(input logic [DW-1:0] b);
    tx_got = '0; tx_n = 0;
    exp_tx.push_back(b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    while (!ti) @(negedge clk);
    @(negedge clk); ti_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0;
  endtask

  task automatic recv(input logic [DW-1:0] b);
    rx_pat = b; rx_idx = 0; oe_in_rx = 0; rx_mode = 1'b1;
    exp_rx.push_back(b);
    @(negedge clk); rx_en = 1'b1; ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    while (!ri) @(negedge clk);
    @(negedge clk); ri_clr = 1'b1; rx_en = 1'b0;
    @(negedge clk); ri_clr = 1'b0;
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle_for(3);
    chk(sclk_o == 1'b1, "R1 sclk idle", sclk_o, 1);
    chk(sdata_oe == 1'b0, "R1 oe off", sdata_oe, 0);
    chk(ti == 1'b0 && ri == 1'b0, "R1 flags clear", {ti, ri}, 0);
    chk(rd_data == '0, "R1 rd_data zero", rd_data, 0);
    rst_n = 1'b1;
    idle_for(4);

    send(8'hA5); send(8'h01); send(8'h80); send(8'hFF); send(8'h00);
    recv(8'h3C); recv(8'h81); recv(8'hFE);

    // R5: flag sticky until cleared
    tx_got = '0; tx_n = 0; exp_tx.push_back(8'h6D);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h6D;
    @(negedge clk); wr_en = 1'b0;
    while (!ti) @(negedge clk);
    idle_for(2 * CYC);
    chk(ti == 1'b1, "R5 ti held", ti, 1);
    ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0; @(negedge clk);
    chk(ti == 1'b0, "R5 ti cleared", ti, 0);

    // R7: clear with receive disabled
    begin
      int unsigned f0;
      f0 = falls;
      rx_en = 1'b0; ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0;
      idle_for(3 * CYC);
      chk(falls == f0, "R7 no clock pulses", falls, f0);
      chk(ri == 1'b0 && sclk_o == 1'b1, "R7 ri low sclk high", {ri, sclk_o}, 1);
    end

    // R8: write and receive trigger during a transmit are ignored
    begin
      int unsigned f0;
      tx_got = '0; tx_n = 0; exp_tx.push_back(8'h5A);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
      @(negedge clk); wr_en = 1'b0;
      idle_for(2 * CYC);
      wr_en = 1'b1; wr_data = 8'hC3; @(negedge clk); wr_en = 1'b0;
      idle_for(CYC);
      rx_en = 1'b1; ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0; rx_en = 1'b0;
      while (!ti) @(negedge clk);
      f0 = falls;
      ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0;
      idle_for(3 * CYC);
      chk(falls == f0, "R8 no follow-on transfer", falls, f0);
      chk(ri == 1'b0 && sdata_oe == 1'b0, "R8 no receive, R9 oe off", {ri, sdata_oe}, 0);
    end

    chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R2 R6 all bytes seen",
        exp_tx.size() + exp_rx.size(), 0);
    finish_run();
  end
endmodule